// File: doc/BRIEF.md
# Sampling Converter Serial Port

This block is the digital side of a differential sampling converter: the timing logic and the serial output port. A convert strobe starts a conversion and freezes the input sample. The serial clock then moves the conversion forward one step per rising edge and shifts the result out on a single data line. An output-enable says when that line would be driven; when it is low, the line is high impedance. The parallel result comes from an ideal behavioural source and is latched on each convert edge. The word sent during a conversion is always the one latched at the start of the conversion before it.

The whole block runs on one fast system clock. Both the convert strobe and the serial clock are sampled on that clock, and the block acts on their rising edges. Convert edges that arrive while the serial clock sits still are counted. A short run of them drops the block into a light power-down state (nap), and a longer run drops it into a deep one (sleep). Any serial clock edge brings it back. A parameter sets the resolution to 12 or 14 bits. With 12 bits, the 14-slot frame ends in two zero filler bits.

Top module: `sar_serial_port`

## Requirements
- R1: While reset is asserted and right after it is released, `sdo_oe_o`, `sdo_o`, `hold_o`, `nap_o` and `sleep_o` are all 0.
- R2: A rising edge on `conv_i` that is accepted (block not asleep) sets `hold_o` to 1. The 16th counted rising edge of `sck_i` after it returns `hold_o` to 0, and `hold_o` stays 0 until the next accepted convert edge.
- R3: Each frame has 14 bit slots. On counted serial clock edges 1 through 14 after an accepted convert edge, `sdo_o` carries frame bit 13, then 12, and so on down to bit 0. The most significant bit comes first, and each bit is valid from that edge until the next counted edge.
- R4: `sdo_oe_o` is 0 from an accepted convert edge up to the first counted serial clock edge. It is 1 from counted edge 1 through counted edge 14. It returns to 0 at counted edge 15 and stays 0 while `hold_o` is 0.
- R5: The word in the frame is the `result_i` value latched at the previous accepted convert edge. The first frame after reset carries all zeros.
- R6: With `RES_BITS` = 14, frame bits 13..0 are result bits 13..0. With `RES_BITS` = 12, frame bits 13..2 are result bits 11..0 and frame bits 1..0 are 0.
- R7: If a serial clock rising edge is detected in the same system clock cycle as an accepted convert edge, that serial edge is not counted. Every frame bit then appears one serial clock later.
- R8: Two convert edges with no serial clock edge between them set `nap_o` to 1. `nap_o` stays 1 while the count of such edges is 2 or 3.
- R9: A fourth or later convert edge with no serial clock edge in between sets `sleep_o` to 1 and clears `nap_o`. `nap_o` and `sleep_o` are never both 1.
- R10: Any serial clock rising edge clears `nap_o`, `sleep_o` and the convert-pulse count. A single convert edge after that does not set `nap_o`.
- R11: While `sleep_o` is 1, convert edges neither latch `result_i` nor restart the sequence. The serial clock edge that wakes the block is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling both strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Convert strobe; its rising edge holds the sample and starts a conversion |
| sck_i | input | 1 | Serial clock; its rising edges advance conversion and shifting |
| result_i | input | RES_BITS | Parallel conversion result from the behavioural source |
| sdo_o | output | 1 | Serial data, most significant bit first |
| sdo_oe_o | output | 1 | High when the serial line is driven, low for high impedance |
| hold_o | output | 1 | 1 in hold/convert phase, 0 in sample phase |
| nap_o | output | 1 | Light power-down state |
| sleep_o | output | 1 | Deep power-down state |

## Verification
The bench goes after the one-word latency first. A design that sends the current sample instead of the previous one shows it right away in the frame after reset, which must be all zeros. It drives a convert edge and a serial edge in the same system cycle: a design that counts that serial edge shifts every bit one slot early and puts out 15 enabled slots or a misaligned word. The power-down runs hold the serial clock high and low, and include a fifth pulse during sleep. A design that latches during sleep, or counts the waking edge, sends the wrong word or loses its most significant bit. Both resolutions are compared every cycle, so filler bits placed at the wrong end of the 12-bit frame show up as mismatches.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

   // Events decoded from the two sampled strobes in one system cycle.
   typedef struct packed {
      logic conv_rise;
      logic sck_rise;
   } port_edges_t;

   // Sequencer commands passed to the output shifter.
   typedef struct packed {
      logic start;
      logic shift;
      logic release_line;
   } seq_cmd_t;

   localparam int unsigned DEF_RES_BITS     = 14;
   localparam int unsigned DEF_FRAME_BITS   = 14;
   localparam int unsigned DEF_WORD_CLKS    = 16;
   localparam int unsigned DEF_NAP_PULSES   = 2;
   localparam int unsigned DEF_SLEEP_PULSES = 4;

endpackage

// File: rtl/sar_edge_detect.sv
module sar_edge_detect
   import sar_port_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        conv_i,
   input  logic        sck_i,
   output port_edges_t edges_o
);

   localparam int unsigned NUM_LINES = 2;

   logic [NUM_LINES-1:0] line_now;
   logic [NUM_LINES-1:0] line_prev;
   logic [NUM_LINES-1:0] line_rise;

   assign line_now = {conv_i, sck_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_prev <= '0;
      else        line_prev <= line_now;
   end

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_rise
      assign line_rise[g] = line_now[g] & ~line_prev[g];
   end

   assign edges_o.conv_rise = line_rise[1];
   assign edges_o.sck_rise  = line_rise[0];

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
   import sar_port_pkg::*;
#(
   parameter int unsigned FRAME_BITS = DEF_FRAME_BITS,
   parameter int unsigned WORD_CLKS  = DEF_WORD_CLKS
) (
   input  logic        clk,
   input  logic        rst_n,
   input  port_edges_t edges_i,
   input  logic        asleep_i,
   output seq_cmd_t    cmd_o,
   output logic        hold_o
);

   localparam int unsigned CNT_W = $clog2(WORD_CLKS + 1);
   localparam logic [CNT_W-1:0] LAST_EDGE    = CNT_W'(WORD_CLKS);
   localparam logic [CNT_W-1:0] LAST_BIT     = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] RELEASE_EDGE = CNT_W'(FRAME_BITS + 1);

   if (FRAME_BITS + 1 > WORD_CLKS) begin : g_bad_window
      $error("sar_sequencer: frame plus release slot must fit in WORD_CLKS");
   end

   logic [CNT_W-1:0] edge_cnt;
   logic [CNT_W-1:0] edge_cnt_nxt;
   logic             hold_q;
   logic             conv_go;
   logic             sck_go;

   // A serial edge landing with the convert edge is dropped (late strobe).
   assign conv_go      = edges_i.conv_rise & ~asleep_i;
   assign sck_go       = edges_i.sck_rise & ~asleep_i & ~edges_i.conv_rise & hold_q;
   assign edge_cnt_nxt = edge_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         hold_q   <= 1'b0;
      end else if (conv_go) begin
         edge_cnt <= '0;
         hold_q   <= 1'b1;
      end else if (sck_go) begin
         edge_cnt <= edge_cnt_nxt;
         if (edge_cnt_nxt == LAST_EDGE) hold_q <= 1'b0;
      end
   end

   assign cmd_o.start        = conv_go;
   assign cmd_o.shift        = sck_go && (edge_cnt_nxt <= LAST_BIT);
   assign cmd_o.release_line = sck_go && (edge_cnt_nxt == RELEASE_EDGE);
   assign hold_o             = hold_q;

   AST_HOLD_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_i.conv_rise && !asleep_i) |=> hold_o); // R2

   AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      edge_cnt <= LAST_EDGE); // R2

   AST_FROZEN_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      asleep_i |=> $stable(hold_o)); // R11

endmodule

// File: rtl/sar_shifter.sv
module sar_shifter
   import sar_port_pkg::*;
#(
   parameter int unsigned RES_BITS   = DEF_RES_BITS,
   parameter int unsigned FRAME_BITS = DEF_FRAME_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  seq_cmd_t            cmd_i,
   input  logic                hold_i,
   input  logic [RES_BITS-1:0] result_i,
   output logic                sdo_o,
   output logic                sdo_oe_o
);

   localparam int unsigned PAD_BITS = FRAME_BITS - RES_BITS;

   if (RES_BITS > FRAME_BITS || RES_BITS < 2) begin : g_bad_res
      $error("sar_shifter: RES_BITS must lie in 2..FRAME_BITS");
   end

   logic [RES_BITS-1:0]   pending_q;
   logic [FRAME_BITS-1:0] frame_w;
   logic [FRAME_BITS-1:0] shift_q;
   logic                  sdo_q;
   logic                  oe_q;

   if (PAD_BITS == 0) begin : g_full
      assign frame_w = pending_q;
   end else begin : g_padded
      assign frame_w = {pending_q, {PAD_BITS{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= '0;
         shift_q   <= '0;
         sdo_q     <= 1'b0;
         oe_q      <= 1'b0;
      end else if (cmd_i.start) begin
         pending_q <= result_i;
         shift_q   <= frame_w;
         sdo_q     <= 1'b0;
         oe_q      <= 1'b0;
      end else if (cmd_i.shift) begin
         sdo_q   <= shift_q[FRAME_BITS-1];
         shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
         oe_q    <= 1'b1;
      end else if (cmd_i.release_line) begin
         sdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end
   end

   assign sdo_o    = sdo_q;
   assign sdo_oe_o = oe_q;

   AST_QUIET_WHEN_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_i |-> !sdo_oe_o); // R4

   AST_QUIET_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i.start |=> !sdo_oe_o); // R4

endmodule

// File: rtl/sar_power_monitor.sv
module sar_power_monitor
   import sar_port_pkg::*;
#(
   parameter int unsigned NAP_PULSES   = DEF_NAP_PULSES,
   parameter int unsigned SLEEP_PULSES = DEF_SLEEP_PULSES
) (
   input  logic        clk,
   input  logic        rst_n,
   input  port_edges_t edges_i,
   output logic        nap_o,
   output logic        sleep_o
);

   localparam int unsigned PC_W = $clog2(SLEEP_PULSES + 1);
   localparam logic [PC_W-1:0] NAP_AT   = PC_W'(NAP_PULSES);
   localparam logic [PC_W-1:0] SLEEP_AT = PC_W'(SLEEP_PULSES);

   if (NAP_PULSES < 1 || NAP_PULSES >= SLEEP_PULSES) begin : g_bad_pulses
      $error("sar_power_monitor: need 1 <= NAP_PULSES < SLEEP_PULSES");
   end

   logic [PC_W-1:0] pulse_cnt;
   logic [PC_W-1:0] pulse_nxt;
   logic            nap_q;
   logic            sleep_q;

   assign pulse_nxt = (pulse_cnt == SLEEP_AT) ? pulse_cnt : pulse_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_cnt <= '0;
         nap_q     <= 1'b0;
         sleep_q   <= 1'b0;
      end else if (edges_i.sck_rise) begin
         pulse_cnt <= '0;
         nap_q     <= 1'b0;
         sleep_q   <= 1'b0;
      end else if (edges_i.conv_rise) begin
         pulse_cnt <= pulse_nxt;
         nap_q     <= (pulse_nxt >= NAP_AT) && (pulse_nxt < SLEEP_AT);
         sleep_q   <= (pulse_nxt >= SLEEP_AT);
      end
   end

   assign nap_o   = nap_q;
   assign sleep_o = sleep_q;

   AST_STATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(nap_o && sleep_o)); // R9

   AST_NAP_NEEDS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nap_o) |-> $past(edges_i.conv_rise)); // R8

   AST_WAKE_ON_SCK: assert property (@(posedge clk) disable iff (!rst_n)
      edges_i.sck_rise |=> (!sleep_o && !nap_o)); // R10

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
   import sar_port_pkg::*;
#(
   parameter int unsigned RES_BITS     = DEF_RES_BITS,
   parameter int unsigned FRAME_BITS   = DEF_FRAME_BITS,
   parameter int unsigned WORD_CLKS    = DEF_WORD_CLKS,
   parameter int unsigned NAP_PULSES   = DEF_NAP_PULSES,
   parameter int unsigned SLEEP_PULSES = DEF_SLEEP_PULSES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_i,
   input  logic                sck_i,
   input  logic [RES_BITS-1:0] result_i,
   output logic                sdo_o,
   output logic                sdo_oe_o,
   output logic                hold_o,
   output logic                nap_o,
   output logic                sleep_o
);

   if (RES_BITS != 12 && RES_BITS != 14) begin : g_bad_variant
      $error("sar_serial_port: RES_BITS must be 12 or 14");
   end

   port_edges_t edges;
   seq_cmd_t    cmd;
   logic        asleep;
   logic        hold;

   sar_edge_detect u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .conv_i  (conv_i),
      .sck_i   (sck_i),
      .edges_o (edges)
   );

   sar_power_monitor #(
      .NAP_PULSES   (NAP_PULSES),
      .SLEEP_PULSES (SLEEP_PULSES)
   ) u_power (
      .clk     (clk),
      .rst_n   (rst_n),
      .edges_i (edges),
      .nap_o   (nap_o),
      .sleep_o (asleep)
   );

   sar_sequencer #(
      .FRAME_BITS (FRAME_BITS),
      .WORD_CLKS  (WORD_CLKS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .edges_i  (edges),
      .asleep_i (asleep),
      .cmd_o    (cmd),
      .hold_o   (hold)
   );

   sar_shifter #(
      .RES_BITS   (RES_BITS),
      .FRAME_BITS (FRAME_BITS)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_i    (cmd),
      .hold_i   (hold),
      .result_i (result_i),
      .sdo_o    (sdo_o),
      .sdo_oe_o (sdo_oe_o)
   );

   assign hold_o  = hold;
   assign sleep_o = asleep;

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!sdo_oe_o && !hold_o && !nap_o && !sleep_o)); // R1

   AST_DRIVE_INSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe_o |-> hold_o); // R4

endmodule

// File: tb/sar_serial_port_model.sv
module sar_serial_port_model #(
   parameter int RES_BITS = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv,
   input  logic                sck,
   input  logic [RES_BITS-1:0] result,
   output logic                exp_oe,
   output logic                exp_sdo,
   output logic                exp_hold,
   output logic                exp_nap,
   output logic                exp_sleep
);
   // Behavioural reference: 14-slot frame, 16 counted edges per conversion.
   int latched[$];
   int word;
   int k;
   int pulses;
   bit conv_prev, sck_prev;
   bit cr, sr, asleep;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched.delete();
         latched.push_back(0);
         word = 0; k = 0; pulses = 0;
         conv_prev = 0; sck_prev = 0;
         exp_oe = 0; exp_sdo = 0; exp_hold = 0; exp_nap = 0; exp_sleep = 0;
      end else begin
         cr = conv && !conv_prev;
         sr = sck && !sck_prev;
         conv_prev = conv;
         sck_prev  = sck;
         asleep = exp_sleep;
         if (cr && !asleep) begin
            word = latched.pop_front() << (14 - RES_BITS);
            latched.push_back(int'(result));
            k = 0; exp_hold = 1; exp_oe = 0; exp_sdo = 0;
         end else if (sr && !asleep && exp_hold) begin
            k = k + 1;
            if (k <= 14) begin
               exp_sdo = ((word >> (14 - k)) & 1) != 0;
               exp_oe  = 1;
            end else if (k == 15) begin
               exp_oe = 0; exp_sdo = 0;
            end
            if (k == 16) exp_hold = 0;
         end
         if (sr) begin
            pulses = 0; exp_nap = 0; exp_sleep = 0;
         end else if (cr) begin
            if (pulses < 4) pulses = pulses + 1;
            exp_nap   = (pulses >= 2) && (pulses < 4);
            exp_sleep = (pulses >= 4);
         end
      end
   end
endmodule

// File: tb/sar_serial_port_test.sv
module sar_serial_port_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        conv = 0;
   logic        sck = 0;
   logic [13:0] res = '0;

   logic sdo14, oe14, hold14, nap14, sleep14;
   logic sdo12, oe12, hold12, nap12, sleep12;
   logic e_sdo14, e_oe14, e_hold14, e_nap14, e_sleep14;
   logic e_sdo12, e_oe12, e_hold12, e_nap12, e_sleep12;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_serial_port #(.RES_BITS(14)) uut (
      .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .result_i(res),
      .sdo_o(sdo14), .sdo_oe_o(oe14), .hold_o(hold14), .nap_o(nap14), .sleep_o(sleep14));

   sar_serial_port #(.RES_BITS(12)) uut12 (
      .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .result_i(res[11:0]),
      .sdo_o(sdo12), .sdo_oe_o(oe12), .hold_o(hold12), .nap_o(nap12), .sleep_o(sleep12));

   sar_serial_port_model #(.RES_BITS(14)) ref14 (
      .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck), .result(res),
      .exp_oe(e_oe14), .exp_sdo(e_sdo14), .exp_hold(e_hold14),
      .exp_nap(e_nap14), .exp_sleep(e_sleep14));

   sar_serial_port_model #(.RES_BITS(12)) ref12 (
      .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck), .result(res[11:0]),
      .exp_oe(e_oe12), .exp_sdo(e_sdo12), .exp_hold(e_hold12),
      .exp_nap(e_nap12), .exp_sleep(e_sleep12));

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the reference, away from the rising edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 oe14", oe14, e_oe14);
         chk("R2 hold14", hold14, e_hold14);
         chk("R8 nap14", nap14, e_nap14);
         chk("R9 sleep14", sleep14, e_sleep14);
         if (e_oe14) chk("R3 sdo14", sdo14, e_sdo14);
         chk("R4 oe12", oe12, e_oe12);
         chk("R2 hold12", hold12, e_hold12);
         chk("R8 nap12", nap12, e_nap12);
         chk("R9 sleep12", sleep12, e_sleep12);
         if (e_oe12) chk("R6 sdo12", sdo12, e_sdo12);
      end
   end

   task automatic sck_pulses(input int n, inout logic [13:0] g14, inout logic [13:0] g12,
                             inout int c14, inout int c12);
      for (int i = 0; i < n; i++) begin
         sck = 1;
         @(negedge clk);
         if (oe14) begin g14 = {g14[12:0], sdo14}; c14++; end
         if (oe12) begin g12 = {g12[12:0], sdo12}; c12++; end
         sck = 0;
         @(negedge clk);
      end
   endtask

   task automatic frame(input logic [13:0] value, input bit late,
                        output logic [13:0] g14, output logic [13:0] g12,
                        output int c14, output int c12);
      g14 = '0; g12 = '0; c14 = 0; c12 = 0;
      res = value;
      conv = 1;
      if (late) sck = 1;
      @(negedge clk);
      conv = 0; sck = 0;
      @(negedge clk);
      sck_pulses(18, g14, g12, c14, c12);
   endtask

   task automatic conv_pulse(input logic [13:0] value);
      res = value;
      conv = 1;
      @(negedge clk);
      conv = 0;
      @(negedge clk);
   endtask

   logic [13:0] g14, g12;
   int c14, c12;

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs quiet during reset
      chk("R1 oe", oe14, 0); chk("R1 hold", hold14, 0);
      chk("R1 nap", nap14, 0); chk("R1 sleep", sleep14, 0); chk("R1 sdo", sdo14, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 oe after release", oe14, 0);
      chk("R1 hold after release", hold14, 0);

      // R5: first word after reset is zero, then one-word latency
      frame(14'h2AAA, 0, g14, g12, c14, c12);
      chk("R5 first word", g14, 0);
      chk("R4 enabled slots", c14, 14);
      chk("R2 hold released", hold14, 0);
      frame(14'h3FFF, 0, g14, g12, c14, c12);
      chk("R5 previous word", g14, 14'h2AAA);
      chk("R6 12-bit frame", g12, {12'hAAA, 2'b00});
      frame(14'h1234, 0, g14, g12, c14, c12);
      chk("R3 msb first", g14, 14'h3FFF);
      chk("R6 12-bit padding", g12, {12'hFFF, 2'b00});
      chk("R6 12-bit slots", c12, 14);

      // R7: serial edge together with convert edge is not counted
      frame(14'h0F0F, 1, g14, g12, c14, c12);
      chk("R7 late word", g14, 14'h1234);
      chk("R7 late slots", c14, 14);
      frame(14'h0001, 0, g14, g12, c14, c12);
      chk("R7 after late", g14, 14'h0F0F);

      // Restart during a frame
      res = 14'h1C3A; conv = 1; @(negedge clk); conv = 0; @(negedge clk);
      sck_pulses(5, g14, g12, c14, c12);
      frame(14'h2222, 0, g14, g12, c14, c12);
      chk("R5 restart word", g14, 14'h1C3A);

      // R8 / R10: nap entry and exit, SCK static low
      conv_pulse(14'h0100);
      chk("R8 one pulse no nap", nap14, 0);
      conv_pulse(14'h0200);
      chk("R8 nap set", nap14, 1);
      conv_pulse(14'h0300);
      chk("R8 nap kept at three", nap14, 1);
      chk("R9 no sleep at three", sleep14, 0);
      sck_pulses(1, g14, g12, c14, c12);
      chk("R10 nap cleared", nap14, 0);
      conv_pulse(14'h0400);
      chk("R10 count cleared", nap14, 0);

      // R9 / R11: sleep with SCK static high
      sck = 1; @(negedge clk);
      conv_pulse(14'h0011);
      conv_pulse(14'h0022);
      conv_pulse(14'h0033);
      conv_pulse(14'h0044);
      chk("R9 sleep set", sleep14, 1);
      chk("R9 nap cleared in sleep", nap14, 0);
      conv_pulse(14'h0055);
      chk("R9 sleep kept", sleep14, 1);
      sck = 0; @(negedge clk);
      chk("R9 falling sck keeps sleep", sleep14, 1);
      sck = 1; @(negedge clk);
      chk("R10 woken", sleep14, 0);
      sck = 0; @(negedge clk);
      g14 = '0; g12 = '0; c14 = 0; c12 = 0;
      sck_pulses(18, g14, g12, c14, c12);
      chk("R11 waking edge uncounted", g14, 14'h0033);
      chk("R11 full slot count", c14, 14);
      frame(14'h1111, 0, g14, g12, c14, c12);
      chk("R11 no latch while asleep", g14, 14'h0044);

      repeat (4) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule